// File: doc/BRIEF.md
# Converter Soft-Start and Fault Sequencer

This block is the digital start-up and protection controller of a synchronous buck converter. It runs from a clock at the switching-oscillator rate and reads the outputs of the converter's analog comparators: supply-good, shutdown request, over-current, under-voltage, over-voltage and a flag saying that the programmed current-limit setting is out of range or floating. It drives a stepped reference code into the error amplifier, the track/hold control of the current-limit sampler, the gate-driver enable, a request that forces the low-side switch on, and a latched-fault status.

After the supply becomes good, or a shutdown request is released, the block runs a short threshold-sampling phase. It then raises the reference from zero to full scale in 40 equal steps spread over 512 oscillator periods, and stays in regulation after that. The first over-current event causes a hiccup: the gates go off for a fixed interval and the ramp restarts from zero. The second event since power-on or since the last shutdown latches the gates off. An under-voltage event in regulation latches off at once. Over-voltage only forces the low-side switch on while the comparator is asserted and never latches. All comparator inputs pass through two-flop synchronizers.

Top module: `softstart_seq`

## Requirements
- R1: While `supply_ok` is low (after synchronization), the block is inhibited: `gate_en`, `thr_track`, `force_lowside`, `fault_latched`, `thr_use_dflt` are 0 and `ref_code` is 0. This includes clearing a latched fault.
- R2: Each initialization starts with a sampling phase in which `thr_track` is 1 for exactly `SAMPLE_CYCLES` clock cycles while `gate_en` is 0 and `ref_code` is 0. `thr_track` is 0 in every other state.
- R3: `thr_use_dflt` takes the synchronized value of `thr_range_bad` in the last sampling cycle and holds it until the next sampling phase ends.
- R4: In the n-th cycle after the sampling phase (n = 0 in the first ramp cycle), `ref_code` equals floor(n*RAMP_STEPS/RAMP_CYCLES)*STEP_SIZE. It reaches RAMP_STEPS*STEP_SIZE (200 by default) at n = RAMP_CYCLES and holds that value in regulation. It never decreases while the gates stay enabled.
- R5: `gate_en` is 1 throughout the ramp and regulation states and 0 in all other states.
- R6: On the first over-current event since power-on or shutdown, `gate_en` and `ref_code` go to 0 for exactly `HICCUP_CYCLES` cycles without raising `fault_latched`. The ramp then restarts from zero with no new sampling phase.
- R7: On the second such over-current event, `fault_latched` goes to 1 and `gate_en` to 0. Both stay there, ignoring further over-current events, until a supply drop or a shutdown request.
- R8: An under-voltage flag in regulation sets `fault_latched` and clears `gate_en`. An under-voltage flag during the ramp is ignored.
- R9: `force_lowside` is 1 exactly while the synchronized over-voltage flag is 1 and the gates are enabled. It sets no latch.
- R10: While `shdn_req` is 1, the gates are off and any latched fault is cleared. On release, a full sampling phase and ramp follow. The over-current event count is cleared, so the next over-current event causes a hiccup again.
- R11: Each input passes through two flops. A state-driven output responds 3 clock edges after an input change, and `force_lowside` responds 2 edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above power-on threshold (async) |
| shdn_req | input | 1 | Compensation node pulled below disable level (async) |
| oc_trip | input | 1 | Low-side drop above twice the held threshold (async) |
| uv_trip | input | 1 | Feedback below half of reference (async) |
| ov_trip | input | 1 | Feedback above over-voltage trip, with analog hysteresis (async) |
| thr_range_bad | input | 1 | Programmed limit too high or setting floating (async) |
| ref_code | output | REF_W | Stepped reference code for the error amplifier |
| thr_track | output | 1 | 1: sampler tracks and sense source on; 0: hold, source off |
| thr_use_dflt | output | 1 | Use the built-in 0.3 V default threshold |
| gate_en | output | 1 | Gate drivers allowed to switch |
| force_lowside | output | 1 | High-side off, low-side on |
| fault_latched | output | 1 | Latched-off fault status |

## Verification
A change on an input reaches the state register on the third rising edge and the over-voltage override on the second. The bench drives inputs on falling edges and counts exactly that many falling edges before it samples. Phase lengths are measured by counting falling-edge samples of `thr_track` and `gate_en`. Ramp checks are keyed to the first falling edge after `thr_track` drops, and every ramp cycle is compared against the floor formula.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

    typedef enum logic [2:0] {
        ST_INHIBIT,
        ST_SAMPLE,
        ST_RAMP,
        ST_RUN,
        ST_HICCUP,
        ST_LATCH,
        ST_OFF
    } seq_state_t;

    typedef struct packed {
        logic supply;
        logic shdn;
        logic oc;
        logic uv;
        logic ov;
        logic rbad;
    } cmp_flags_t;

    localparam int FLAG_W = $bits(cmp_flags_t);

    function automatic logic gates_active(input seq_state_t s);
        return (s == ST_RAMP) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '0;
                    else     pipe[i] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '0;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
    parameter int RAMP_STEPS  = 40,
    parameter int RAMP_CYCLES = 512,
    localparam int STEP_W = $clog2(RAMP_STEPS + 1),
    localparam int CYC_W  = $clog2(RAMP_CYCLES + 1),
    localparam int ACC_W  = $clog2(RAMP_CYCLES + RAMP_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    logic [CYC_W-1:0] cyc;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;

    assign done    = (cyc == CYC_W'(RAMP_CYCLES));
    assign acc_sum = acc + ACC_W'(RAMP_STEPS);

    // Bresenham-style spreading: after n advances, step = floor(n*STEPS/CYCLES)
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cyc  <= '0;
            acc  <= '0;
            step <= '0;
        end else if (adv && !done) begin
            cyc <= cyc + CYC_W'(1);
            if (acc_sum >= ACC_W'(RAMP_CYCLES)) begin
                acc  <= acc_sum - ACC_W'(RAMP_CYCLES);
                step <= step + STEP_W'(1);
            end else begin
                acc <= acc_sum;
            end
        end
    end
endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
    import softstart_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 256,
    parameter int HICCUP_CYCLES = 128,
    parameter int OC_LIMIT      = 2,
    localparam int TMR_MAX = (SAMPLE_CYCLES > HICCUP_CYCLES) ? SAMPLE_CYCLES : HICCUP_CYCLES,
    localparam int TMR_W   = $clog2(TMR_MAX + 1),
    localparam int OCN_W   = $clog2(OC_LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  cmp_flags_t flg,
    input  logic       ramp_done,
    output seq_state_t state,
    output logic       use_dflt
);
    seq_state_t       nx;
    logic [TMR_W-1:0] tmr, tmr_nx;
    logic [OCN_W-1:0] ocn, ocn_nx;
    logic             dflt_nx;

    always_comb begin
        nx      = state;
        tmr_nx  = tmr + TMR_W'(1);
        ocn_nx  = ocn;
        dflt_nx = use_dflt;
        if (!flg.supply) begin
            nx      = ST_INHIBIT;
            ocn_nx  = '0;
            dflt_nx = 1'b0;
        end else if (flg.shdn) begin
            nx     = ST_OFF;
            ocn_nx = '0;
        end else begin
            unique case (state)
                ST_INHIBIT, ST_OFF: begin
                    nx     = ST_SAMPLE;
                    tmr_nx = '0;
                end
                ST_SAMPLE: begin
                    if (tmr == TMR_W'(SAMPLE_CYCLES - 1)) begin
                        nx      = ST_RAMP;
                        dflt_nx = flg.rbad;
                    end
                end
                ST_RAMP, ST_RUN: begin
                    if (state == ST_RUN && flg.uv) begin
                        nx = ST_LATCH;
                    end else if (flg.oc) begin
                        if (ocn == OCN_W'(OC_LIMIT - 1)) begin
                            nx = ST_LATCH;
                        end else begin
                            nx     = ST_HICCUP;
                            tmr_nx = '0;
                            ocn_nx = ocn + OCN_W'(1);
                        end
                    end else if (state == ST_RAMP && ramp_done) begin
                        nx = ST_RUN;
                    end
                end
                ST_HICCUP: begin
                    if (tmr == TMR_W'(HICCUP_CYCLES - 1)) nx = ST_RAMP;
                end
                ST_LATCH: nx = ST_LATCH;
                default:  nx = ST_INHIBIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_INHIBIT;
            tmr      <= '0;
            ocn      <= '0;
            use_dflt <= 1'b0;
        end else begin
            state    <= nx;
            tmr      <= tmr_nx;
            ocn      <= ocn_nx;
            use_dflt <= dflt_nx;
        end
    end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import softstart_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 256,
    parameter int HICCUP_CYCLES = 128,
    parameter int RAMP_STEPS    = 40,
    parameter int RAMP_CYCLES   = 512,
    parameter int STEP_SIZE     = 5,
    parameter int OC_LIMIT      = 2,
    localparam int REF_MAX = RAMP_STEPS * STEP_SIZE,
    localparam int REF_W   = $clog2(REF_MAX + 1),
    localparam int STEP_W  = $clog2(RAMP_STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             shdn_req,
    input  logic             oc_trip,
    input  logic             uv_trip,
    input  logic             ov_trip,
    input  logic             thr_range_bad,
    output logic [REF_W-1:0] ref_code,
    output logic             thr_track,
    output logic             thr_use_dflt,
    output logic             gate_en,
    output logic             force_lowside,
    output logic             fault_latched
);
    cmp_flags_t        raw, flg;
    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic              ramp_done;

    assign raw = '{supply: supply_ok, shdn: shdn_req, oc: oc_trip,
                   uv: uv_trip, ov: ov_trip, rbad: thr_range_bad};

    ss_sync #(.W(FLAG_W), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw),
        .q_sync  (flg)
    );

    ss_fsm #(
        .SAMPLE_CYCLES (SAMPLE_CYCLES),
        .HICCUP_CYCLES (HICCUP_CYCLES),
        .OC_LIMIT      (OC_LIMIT)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .flg       (flg),
        .ramp_done (ramp_done),
        .state     (state),
        .use_dflt  (thr_use_dflt)
    );

    ss_ramp #(.RAMP_STEPS(RAMP_STEPS), .RAMP_CYCLES(RAMP_CYCLES)) ramp_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (!gates_active(state)),
        .adv  (state == ST_RAMP),
        .step (step),
        .done (ramp_done)
    );

    assign gate_en       = gates_active(state);
    assign thr_track     = (state == ST_SAMPLE);
    assign fault_latched = (state == ST_LATCH);
    assign force_lowside = gate_en && flg.ov;
    assign ref_code      = gate_en ? REF_W'(step) * REF_W'(STEP_SIZE) : '0;
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
    parameter int REF_W   = 8,
    parameter int REF_MAX = 200
) (
    input logic             clk,
    input logic             rst,
    input logic [REF_W-1:0] ref_code,
    input logic             thr_track,
    input logic             gate_en,
    input logic             force_lowside,
    input logic             fault_latched
);
    // R2
    track_gates_off_chk: assert property (@(posedge clk) disable iff (rst)
        thr_track |-> !gate_en);

    // R7
    latch_gates_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_latched |-> !gate_en && !thr_track);

    // R9
    lowside_needs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        force_lowside |-> gate_en);

    // R4
    ref_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        gate_en && $past(gate_en) |-> ref_code >= $past(ref_code));

    // R4
    ref_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        ref_code <= REF_W'(REF_MAX));
endmodule

bind softstart_seq softstart_seq_chk #(.REF_W(REF_W), .REF_MAX(REF_MAX)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .ref_code      (ref_code),
    .thr_track     (thr_track),
    .gate_en       (gate_en),
    .force_lowside (force_lowside),
    .fault_latched (fault_latched)
);

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
    localparam int SAMP   = 256;
    localparam int HIC    = 128;
    localparam int STEPS  = 40;
    localparam int CYCS   = 512;
    localparam int SSIZE  = 5;
    localparam int REFTOP = STEPS * SSIZE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 0, shdn_req = 0, oc_trip = 0, uv_trip = 0, ov_trip = 0, thr_range_bad = 0;
    logic [7:0] ref_code;
    logic thr_track, thr_use_dflt, gate_en, force_lowside, fault_latched;

    int vecs  = 0;
    int fails = 0;

    always #2 clk = ~clk;

    softstart_seq dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .shdn_req(shdn_req),
        .oc_trip(oc_trip), .uv_trip(uv_trip), .ov_trip(ov_trip),
        .thr_range_bad(thr_range_bad), .ref_code(ref_code), .thr_track(thr_track),
        .thr_use_dflt(thr_use_dflt), .gate_en(gate_en), .force_lowside(force_lowside),
        .fault_latched(fault_latched)
    );

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ref(input int n);
        int k = (n * STEPS) / CYCS;
        if (k > STEPS) k = STEPS;
        return k * SSIZE;
    endfunction

    // Count sampling phase: called at drive time of the triggering input
    task automatic sample_phase(input string tag);
        int cnt;
        tk(2);
        chk({tag, " R11 track not yet"}, int'(thr_track), 0);
        tk(1);
        chk({tag, " R2 track starts"}, int'(thr_track), 1);
        cnt = 1;
        while (thr_track && cnt < 10000) begin
            chk({tag, " R2 gates off in sampling"}, int'(gate_en), 0);
            tk(1);
            if (thr_track) cnt++;
        end
        chk({tag, " R2 sampling length"}, cnt, SAMP);
    endtask

    // Ramp sweep from n=0 (current negedge) up to nmax
    task automatic sweep(input string tag, input int nmax, input bit uv_pulse);
        for (int n = 0; n <= nmax; n++) begin
            if (uv_pulse && n == 100) uv_trip = 1;
            if (uv_pulse && n == 106) uv_trip = 0;
            chk({tag, " R4 ref step"}, int'(ref_code), exp_ref(n));
            chk({tag, " R5 gate on"}, int'(gate_en), 1);
            if (uv_pulse) chk({tag, " R8 uv ignored in ramp"}, int'(fault_latched), 0);
            if (n < nmax) tk(1);
        end
    endtask

    task automatic pulse_oc();
        oc_trip = 1;
        tk(1);
        oc_trip = 0;
    endtask

    task automatic hiccup_phase(input string tag);
        int cnt;
        int trk;
        cnt = 1;
        trk = 0;
        while (!gate_en && cnt < 10000) begin
            chk({tag, " R6 ref zero in hiccup"}, int'(ref_code), 0);
            if (thr_track) trk = 1;
            tk(1);
            if (!gate_en) cnt++;
        end
        chk({tag, " R6 hiccup length"}, cnt, HIC);
        chk({tag, " R6 no resample"}, trk, 0);
    endtask

    initial begin
        tk(5);
        rst = 0;
        tk(1);
        chk("R1 reset gate", int'(gate_en), 0);
        chk("R1 reset ref", int'(ref_code), 0);
        chk("R1 reset fault", int'(fault_latched), 0);
        tk(10);
        chk("R1 inhibited track", int'(thr_track), 0);
        chk("R1 inhibited gate", int'(gate_en), 0);

        // power-on with default threshold selected
        thr_range_bad = 1;
        supply_ok = 1;
        sample_phase("pwr1");
        chk("R3 default captured", int'(thr_use_dflt), 1);
        thr_range_bad = 0;
        sweep("ramp1", CYCS, 1'b1);
        tk(1);
        chk("R4 final ref", int'(ref_code), REFTOP);
        chk("R3 default held", int'(thr_use_dflt), 1);
        tk(5);
        chk("R4 ref holds", int'(ref_code), REFTOP);

        // over-voltage override
        ov_trip = 1;
        tk(1);
        chk("R11 ov latency", int'(force_lowside), 0);
        tk(1);
        chk("R9 force lowside", int'(force_lowside), 1);
        tk(5);
        chk("R9 no latch", int'(fault_latched), 0);
        chk("R9 gates stay on", int'(gate_en), 1);
        ov_trip = 0;
        tk(2);
        chk("R9 release", int'(force_lowside), 0);

        // first over-current: hiccup
        pulse_oc();
        tk(1);
        chk("R11 oc latency", int'(gate_en), 1);
        tk(1);
        chk("R6 gates off", int'(gate_en), 0);
        chk("R6 no latch", int'(fault_latched), 0);
        hiccup_phase("oc1");
        sweep("ramp2", 30, 1'b0);

        // second over-current: latch
        pulse_oc();
        tk(2);
        chk("R7 latched", int'(fault_latched), 1);
        chk("R7 gates off", int'(gate_en), 0);
        tk(40);
        pulse_oc();
        tk(4);
        chk("R7 latch holds", int'(fault_latched), 1);
        chk("R7 ref zero", int'(ref_code), 0);

        // shutdown cycle
        shdn_req = 1;
        tk(3);
        chk("R10 fault cleared", int'(fault_latched), 0);
        chk("R10 gates off", int'(gate_en), 0);
        tk(5);
        chk("R10 still off", int'(thr_track), 0);
        shdn_req = 0;
        sample_phase("shdn");
        chk("R3 programmed threshold", int'(thr_use_dflt), 0);
        sweep("ramp3", 10, 1'b0);
        pulse_oc();
        tk(2);
        chk("R10 count cleared gate", int'(gate_en), 0);
        chk("R10 count cleared no latch", int'(fault_latched), 0);
        hiccup_phase("oc3");
        sweep("ramp4", CYCS, 1'b0);
        tk(1);
        chk("R4 final ref again", int'(ref_code), REFTOP);

        // under-voltage in regulation
        uv_trip = 1;
        tk(2);
        chk("R11 uv latency", int'(fault_latched), 0);
        tk(1);
        chk("R8 uv latch", int'(fault_latched), 1);
        chk("R8 gates off", int'(gate_en), 0);
        uv_trip = 0;

        // supply drop clears everything
        supply_ok = 0;
        tk(3);
        chk("R1 drop clears fault", int'(fault_latched), 0);
        chk("R1 drop gates", int'(gate_en), 0);
        chk("R1 drop ref", int'(ref_code), 0);
        chk("R1 drop default", int'(thr_use_dflt), 0);
        supply_ok = 1;
        sample_phase("pwr2");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule